// File: doc/BRIEF.md
# Linked-Descriptor DMA Mover

This block moves a programmed number of bytes between system memory and a word-wide card data stream. It follows a linked list of descriptors in memory. Software places a list of four-word descriptors in memory, loads the base address, byte count, block size and direction, and pulses `start`. The engine reads each descriptor, moves that descriptor's buffer one 32-bit word at a time, writes the descriptor's status word back with its ownership bit cleared, and then either stops or moves on to the next descriptor in the list.

A descriptor holds four words at consecutive addresses. Offset 0 is the status word, offset 4 the buffer size in bytes, offset 8 the buffer address and offset 12 the link to the next descriptor. The memory side is a single request/grant port with one access in flight. The card side is two valid/ready streams, one toward the card and one from it. When the list completes, a set of sticky interrupt flags is raised together with a one-cycle `done` pulse.

Top module: `dcd_chain_engine`

## Requirements
- R1: While and after reset the engine is idle. `busy`, `done`, `mem_req`, `tx_valid` and `rx_ready` are low, `bytes_left` is 0 and all five interrupt flags are clear.
- R2: A `start` pulse is accepted only when `cfg_dma_en` is 1, `cfg_byte_count` is nonzero and `cfg_block_size` is nonzero. For a card-to-memory transfer (`cfg_to_card` = 0), `cfg_card_ready` must also be 1. A start that is not accepted issues no memory access and leaves `busy`, `bytes_left` and the flags unchanged.
- R3: Each descriptor is fetched with four memory reads in the order base, base+4, base+8, base+12. These return status, size, buffer address and link.
- R4: A size word of 0 is taken as the maximum buffer size `MAX_BUF_BYTES`. A size word above `MAX_BUF_BYTES` is clamped to `MAX_BUF_BYTES`.
- R5: A descriptor moves the smaller of its effective size and the bytes still to be moved. The transfer uses ceil(bytes/4) words at ascending addresses, starting from the buffer address with its two low bits forced to 0. `bytes_left` falls by the bytes moved.
- R6: With `cfg_to_card` = 1, each buffer word is read from memory and presented on `tx_data`, in address order.
- R7: With `cfg_to_card` = 0, each word taken from `rx_data` is written to memory in address order. No memory word beyond the buffer's last word is written.
- R8: After a buffer is moved, the descriptor's status word is written back to the descriptor's own address with bit 31 (ownership) cleared and all other bits kept.
- R9: After the write-back the engine stops if status bit 2 (last) is set or `bytes_left` is 0. Otherwise it fetches the descriptor at the link address.
- R10: On completion `done` pulses for one cycle. In the same cycle `int_data_done`, `int_sdio` and `dst_summary` become 1, together with `dst_transmit` for a memory-to-card transfer or `dst_receive` for a card-to-memory one. The flags hold until the next accepted start clears them.
- R11: A memory request keeps its address, direction and write data stable until granted, and no more than one of `mem_req`, `tx_valid` and `rx_ready` is high at a time.
- R12: While `tx_ready` is low, `tx_valid` stays high and `tx_data` stays stable, and no word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request pulse |
| cfg_dma_en | input | 1 | DMA enable |
| cfg_to_card | input | 1 | 1: memory to card, 0: card to memory; sampled at start |
| cfg_card_ready | input | 1 | Card has read data available |
| cfg_byte_count | input | AW | Total bytes to move |
| cfg_block_size | input | BSW | Card block size; must be nonzero |
| cfg_desc_base | input | AW | Address of the first descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Access completes in this cycle |
| mem_rdata | input | DW | Read data, valid with grant |
| tx_valid | output | 1 | Word toward the card is valid |
| tx_data | output | DW | Word toward the card |
| tx_ready | input | 1 | Card side accepts the word |
| rx_valid | input | 1 | Word from the card is valid |
| rx_data | input | DW | Word from the card |
| rx_ready | output | 1 | Engine accepts a word from the card |
| busy | output | 1 | Engine is walking a list |
| done | output | 1 | One-cycle completion pulse |
| bytes_left | output | AW | Bytes still to move |
| int_data_done | output | 1 | Sticky data-complete flag |
| int_sdio | output | 1 | Sticky card-event flag |
| dst_summary | output | 1 | Sticky DMA summary flag |
| dst_transmit | output | 1 | Sticky transmit-finished flag |
| dst_receive | output | 1 | Sticky receive-finished flag |

## Verification
An accepted start shows up one edge later: `busy` rises, the flags clear and the first descriptor read is already on the port. The bench samples all of this at the following falling edge. Each memory access completes on the edge where it is granted, and each stream word moves on the edge where valid and ready are both high. The bench therefore checks data through logs filled at those edges, never at fixed cycle offsets. `done` and the flags change on the edge that grants the final write-back. The bench waits for `busy` to drop, then reads `bytes_left`, the flags and the memory image at a falling edge. An ignored start is judged five cycles later, by the absence of reads and by unchanged outputs.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_SETUP, S_MRD, S_PUSH, S_PULL, S_MWR, S_WBACK
  } dcd_state_t;

  typedef struct packed {
    logic [31:0] status;
    logic [31:0] size;
    logic [31:0] buf_addr;
    logic [31:0] link;
  } dcd_desc_t;

  localparam int DESC_WORDS = 4;
  localparam int BIT_OWN    = 31;
  localparam int BIT_LAST   = 2;
endpackage

// File: rtl/dcd_desc_store.sv
module dcd_desc_store
  import dcd_pkg::*;
#(
  parameter int W  = 32,
  parameter int N  = DESC_WORDS,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  output dcd_desc_t     desc
);
  logic [W-1:0] words [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst) words[i] <= '0;
        else if (wr_en && wr_idx == IW'(i)) words[i] <= wr_data;
      end
    end
  endgenerate

  assign desc.status   = words[0];
  assign desc.size     = words[1];
  assign desc.buf_addr = words[2];
  assign desc.link     = words[3];
endmodule

// File: rtl/dcd_size_unit.sv
module dcd_size_unit #(
  parameter int AW        = 32,
  parameter int MAX_BYTES = 8192
) (
  input  logic [AW-1:0] size_field,
  input  logic [AW-1:0] remaining,
  output logic [AW-1:0] chunk
);
  localparam logic [AW-1:0] MAXV = AW'(MAX_BYTES);
  logic [AW-1:0] eff;

  always_comb begin
    if (size_field == '0 || size_field > MAXV) eff = MAXV;
    else eff = size_field;
    chunk = (eff < remaining) ? eff : remaining;
  end
endmodule

// File: rtl/dcd_buf_walker.sv
module dcd_buf_walker #(
  parameter int AW = 32,
  parameter int WB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [AW-1:0] load_len,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] step_bytes,
  output logic          last_word
);
  localparam logic [AW-1:0] WBV = AW'(WB);
  logic [AW-1:0] left;

  assign step_bytes = (left >= WBV) ? WBV : left;
  assign last_word  = (left <= WBV);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      left     <= '0;
    end else if (load) begin
      cur_addr <= load_addr & ~(WBV - AW'(1));
      left     <= load_len;
    end else if (step) begin
      cur_addr <= cur_addr + WBV;
      left     <= left - step_bytes;
    end
  end
endmodule

// File: rtl/dcd_chain_engine.sv
module dcd_chain_engine
  import dcd_pkg::*;
#(
  parameter int AW            = 32,
  parameter int DW            = 32,
  parameter int BSW           = 16,
  parameter int MAX_BUF_BYTES = 8192
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cfg_dma_en,
  input  logic          cfg_to_card,
  input  logic          cfg_card_ready,
  input  logic [AW-1:0] cfg_byte_count,
  input  logic [BSW-1:0] cfg_block_size,
  input  logic [AW-1:0] cfg_desc_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] bytes_left,
  output logic          int_data_done,
  output logic          int_sdio,
  output logic          dst_summary,
  output logic          dst_transmit,
  output logic          dst_receive
);
  localparam int IW = $clog2(DESC_WORDS);
  localparam logic [AW-1:0] WORD_BYTES = AW'(DW / 8);
  localparam logic [IW-1:0] LAST_IDX = IW'(DESC_WORDS - 1);

  dcd_state_t    st;
  dcd_desc_t     desc;
  logic [IW-1:0] widx;
  logic [AW-1:0] daddr;
  logic [AW-1:0] rem;
  logic          to_card;
  logic [AW-1:0] chunk;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] step_bytes;
  logic          last_word;
  logic          start_ok;
  logic          walk_step;
  logic          stop_now;

  assign start_ok = start && cfg_dma_en && (cfg_byte_count != '0) &&
                    (cfg_block_size != '0) && (cfg_to_card || cfg_card_ready);
  assign walk_step = (st == S_PUSH && tx_ready) || (st == S_MWR && mem_gnt);
  assign stop_now  = desc.status[BIT_LAST] || (rem == '0);
  assign busy       = (st != S_IDLE);
  assign bytes_left = rem;

  dcd_desc_store #(.W(32), .N(DESC_WORDS)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (st == S_FETCH && mem_gnt),
    .wr_idx  (widx),
    .wr_data (mem_rdata[31:0]),
    .desc    (desc)
  );

  dcd_size_unit #(.AW(AW), .MAX_BYTES(MAX_BUF_BYTES)) u_size (
    .size_field (AW'(desc.size)),
    .remaining  (rem),
    .chunk      (chunk)
  );

  dcd_buf_walker #(.AW(AW), .WB(DW / 8)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .load       (st == S_SETUP),
    .load_addr  (AW'(desc.buf_addr)),
    .load_len   (chunk),
    .step       (walk_step),
    .cur_addr   (cur_addr),
    .step_bytes (step_bytes),
    .last_word  (last_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      widx          <= '0;
      daddr         <= '0;
      rem           <= '0;
      to_card       <= 1'b0;
      mem_req       <= 1'b0;
      mem_we        <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      tx_valid      <= 1'b0;
      tx_data       <= '0;
      rx_ready      <= 1'b0;
      done          <= 1'b0;
      int_data_done <= 1'b0;
      int_sdio      <= 1'b0;
      dst_summary   <= 1'b0;
      dst_transmit  <= 1'b0;
      dst_receive   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_ok) begin
            int_data_done <= 1'b0;
            int_sdio      <= 1'b0;
            dst_summary   <= 1'b0;
            dst_transmit  <= 1'b0;
            dst_receive   <= 1'b0;
            rem           <= cfg_byte_count;
            to_card       <= cfg_to_card;
            daddr         <= cfg_desc_base;
            widx          <= '0;
            mem_req       <= 1'b1;
            mem_we        <= 1'b0;
            mem_addr      <= cfg_desc_base;
            st            <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_gnt) begin
            if (widx == LAST_IDX) begin
              mem_req <= 1'b0;
              st      <= S_SETUP;
            end else begin
              widx     <= widx + IW'(1);
              mem_addr <= mem_addr + WORD_BYTES;
            end
          end
        end
        S_SETUP: begin
          if (to_card) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= AW'(desc.buf_addr) & ~(WORD_BYTES - AW'(1));
            st       <= S_MRD;
          end else begin
            rx_ready <= 1'b1;
            st       <= S_PULL;
          end
        end
        S_MRD: begin
          if (mem_gnt) begin
            mem_req  <= 1'b0;
            tx_valid <= 1'b1;
            tx_data  <= mem_rdata;
            st       <= S_PUSH;
          end
        end
        S_PUSH: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            rem      <= rem - step_bytes;
            mem_req  <= 1'b1;
            if (last_word) begin
              mem_we    <= 1'b1;
              mem_addr  <= daddr;
              mem_wdata <= DW'(desc.status & ~(32'h1 << BIT_OWN));
              st        <= S_WBACK;
            end else begin
              mem_we   <= 1'b0;
              mem_addr <= cur_addr + WORD_BYTES;
              st       <= S_MRD;
            end
          end
        end
        S_PULL: begin
          if (rx_valid) begin
            rx_ready  <= 1'b0;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cur_addr;
            mem_wdata <= rx_data;
            st        <= S_MWR;
          end
        end
        S_MWR: begin
          if (mem_gnt) begin
            rem <= rem - step_bytes;
            if (last_word) begin
              mem_we    <= 1'b1;
              mem_addr  <= daddr;
              mem_wdata <= DW'(desc.status & ~(32'h1 << BIT_OWN));
              st        <= S_WBACK;
            end else begin
              mem_req  <= 1'b0;
              rx_ready <= 1'b1;
              st       <= S_PULL;
            end
          end
        end
        S_WBACK: begin
          if (mem_gnt) begin
            mem_we <= 1'b0;
            if (stop_now) begin
              mem_req       <= 1'b0;
              done          <= 1'b1;
              int_data_done <= 1'b1;
              int_sdio      <= 1'b1;
              dst_summary   <= 1'b1;
              dst_transmit  <= to_card;
              dst_receive   <= ~to_card;
              st            <= S_IDLE;
            end else begin
              daddr    <= AW'(desc.link);
              widx     <= '0;
              mem_addr <= AW'(desc.link);
              st       <= S_FETCH;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcd_chain_engine_chk.sv
module dcd_chain_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          cfg_dma_en,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_gnt,
  input logic          tx_valid,
  input logic [DW-1:0] tx_data,
  input logic          tx_ready,
  input logic          rx_ready,
  input logic          int_data_done,
  input logic          int_sdio,
  input logic          dst_summary,
  input logic          dst_transmit,
  input logic          dst_receive
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !tx_valid && !rx_ready));

  assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !cfg_dma_en && !busy) |=> !busy);

  assert_done_flags_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (int_data_done && int_sdio && dst_summary && (dst_transmit != dst_receive)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_one_channel_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_req, tx_valid, rx_ready}));

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind dcd_chain_engine dcd_chain_engine_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_dcd_chain_engine.sv
`timescale 1ns/1ps
module tb_dcd_chain_engine;
  localparam int MAXB = 64;
  localparam int MEMW = 4096;
  localparam logic [31:0] RXB = 32'hD000_0000;

  typedef struct packed {
    logic        wr;
    logic [31:0] bc;
    logic [31:0] sza;
    logic [31:0] sta;
    logic [31:0] szb;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{1'b1, 32'd40,  32'd16,  32'h8000_0018, 32'd0},
    '{1'b0, 32'd40,  32'd16,  32'h8000_0018, 32'd0},
    '{1'b1, 32'd10,  32'd100, 32'h8000_0018, 32'd8},
    '{1'b0, 32'd200, 32'd0,   32'h8000_0018, 32'd8},
    '{1'b1, 32'd30,  32'd12,  32'h8000_000C, 32'd8},
    '{1'b0, 32'd7,   32'd5,   32'h8000_0018, 32'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cfg_dma_en = 1'b0, cfg_to_card = 1'b0, cfg_card_ready = 1'b0;
  logic [31:0] cfg_byte_count = '0, cfg_desc_base = '0;
  logic [15:0] cfg_block_size = '0;
  logic mem_req, mem_we, mem_gnt, tx_valid, tx_ready, rx_valid, rx_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, tx_data, rx_data, bytes_left;
  logic busy, done, int_data_done, int_sdio, dst_summary, dst_transmit, dst_receive;

  logic [31:0] mem [MEMW];
  logic [15:0] lf = 16'hACE1;
  logic bp_force = 1'b0;
  int rx_k = 0, txn = 0, rdn = 0;
  logic [31:0] txlog [1024];
  logic [31:0] rdlog [1024];
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dcd_chain_engine #(.MAX_BUF_BYTES(MAXB)) dut (.*);

  assign mem_gnt   = mem_req & (lf[0] | lf[3]);
  assign mem_rdata = mem[mem_addr[13:2]];
  assign tx_ready  = ~bp_force & (lf[5] | lf[7]);
  assign rx_valid  = lf[2] | lf[9];
  assign rx_data   = RXB + 32'(rx_k);

  always @(negedge clk) lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};

  always @(posedge clk) begin
    if (mem_req && mem_gnt && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
    if (mem_req && mem_gnt && !mem_we) begin rdlog[rdn % 1024] <= mem_addr; rdn <= rdn + 1; end
    if (tx_valid && tx_ready) begin txlog[txn % 1024] <= tx_data; txn <= txn + 1; end
    if (rx_valid && rx_ready) rx_k <= rx_k + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int idx);
    return 32'h5A00_0000 | 32'(idx);
  endfunction

  function automatic logic [31:0] eff(input logic [31:0] s);
    return (s == 0 || s > MAXB) ? 32'(MAXB) : s;
  endfunction

  function automatic logic [31:0] min32(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  task automatic prep(input vec_t v);
    for (int i = 0; i < MEMW; i++) mem[i] = pat(i);
    mem[32'h40] = v.sta; mem[32'h41] = v.sza; mem[32'h42] = 32'h0000_1002; mem[32'h43] = 32'h0000_0200;
    mem[32'h80] = 32'h8000_0004; mem[32'h81] = v.szb; mem[32'h82] = 32'h0000_2000; mem[32'h83] = 32'h0000_0300;
  endtask

  task automatic kick(input vec_t v);
    @(negedge clk);
    cfg_dma_en = 1'b1; cfg_to_card = v.wr; cfg_card_ready = 1'b1;
    cfg_byte_count = v.bc; cfg_block_size = 16'd512; cfg_desc_base = 32'h100;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int c = 0; c < 5000 && busy; c++) @(negedge clk);
  endtask

  task automatic verify(input vec_t v, input int k0, input int tx0, input int rd0);
    logic [31:0] ca, cb, ra;
    int wa, wb, bad;
    bit useb;
    ca = min32(eff(v.sza), v.bc);
    ra = v.bc - ca;
    useb = !v.sta[2] && ra != 0;
    cb = useb ? min32(eff(v.szb), ra) : 0;
    wa = int'((ca + 3) / 4);
    wb = int'((cb + 3) / 4);
    chk(!busy, "R9 engine stopped", 32'(busy), 0);
    chk(bytes_left == ra - cb, "R5/R9 bytes_left", bytes_left, ra - cb);
    chk(rdlog[rd0 % 1024] == 32'h100 && rdlog[(rd0+1) % 1024] == 32'h104 &&
        rdlog[(rd0+2) % 1024] == 32'h108 && rdlog[(rd0+3) % 1024] == 32'h10C,
        "R3 fetch order", rdlog[(rd0+3) % 1024], 32'h10C);
    chk(mem[32'h40] == (v.sta & 32'h7FFF_FFFF), "R8 writeback A", mem[32'h40], v.sta & 32'h7FFF_FFFF);
    chk(mem[32'h80] == (useb ? 32'h4 : 32'h8000_0004), "R9 writeback B", mem[32'h80],
        useb ? 32'h4 : 32'h8000_0004);
    chk(int_data_done && int_sdio && dst_summary && dst_transmit == v.wr && dst_receive == !v.wr,
        "R10 flags", {27'd0, int_data_done, int_sdio, dst_summary, dst_transmit, dst_receive},
        {27'd0, 3'b111, v.wr, !v.wr});
    bad = 0;
    if (v.wr) begin
      if (txn - tx0 != wa + wb) bad++;
      for (int i = 0; i < wa; i++) if (txlog[(tx0+i) % 1024] != pat(32'h400 + i)) bad++;
      for (int j = 0; j < wb; j++) if (txlog[(tx0+wa+j) % 1024] != pat(32'h800 + j)) bad++;
      chk(bad == 0, "R6/R4 tx stream", 32'(txn - tx0), 32'(wa + wb));
    end else begin
      for (int i = 0; i < wa; i++) if (mem[32'h400 + i] != RXB + 32'(k0 + i)) bad++;
      for (int j = 0; j < wb; j++) if (mem[32'h800 + j] != RXB + 32'(k0 + wa + j)) bad++;
      if (mem[32'h400 + wa] != pat(32'h400 + wa)) bad++;
      if (mem[32'h800 + wb] != pat(32'h800 + wb)) bad++;
      chk(bad == 0, "R7/R4 rx to memory", 32'(bad), 0);
    end
  endtask

  task automatic try_bad(input string what, input logic en, input logic [31:0] bc,
                         input logic [15:0] bs, input logic dir, input logic rdy);
    int r0;
    logic [4:0] f0;
    logic [31:0] b0;
    r0 = rdn; b0 = bytes_left;
    f0 = {int_data_done, int_sdio, dst_summary, dst_transmit, dst_receive};
    @(negedge clk);
    cfg_dma_en = en; cfg_byte_count = bc; cfg_block_size = bs; cfg_to_card = dir;
    cfg_card_ready = rdy; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && rdn == r0 && bytes_left == b0 &&
        {int_data_done, int_sdio, dst_summary, dst_transmit, dst_receive} == f0,
        {"R2 ignored start ", what}, 32'(rdn - r0), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k0, tx0, rd0;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !tx_valid && !rx_ready && bytes_left == 0 &&
        !int_data_done && !int_sdio && !dst_summary && !dst_transmit && !dst_receive,
        "R1 reset state", bytes_left, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after reset", 32'(busy), 0);

    for (int n = 0; n < 6; n++) begin
      prep(VT[n]);
      k0 = rx_k; tx0 = txn; rd0 = rdn;
      kick(VT[n]);
      wait_idle();
      @(negedge clk);
      verify(VT[n], k0, tx0, rd0);
    end

    try_bad("dma off", 1'b0, 32'd40, 16'd512, 1'b1, 1'b1);
    try_bad("zero count", 1'b1, 32'd0, 16'd512, 1'b1, 1'b1);
    try_bad("zero block", 1'b1, 32'd40, 16'd0, 1'b1, 1'b1);
    try_bad("card not ready", 1'b1, 32'd40, 16'd512, 1'b0, 1'b0);

    prep(VT[0]);
    k0 = rx_k; tx0 = txn; rd0 = rdn;
    bp_force = 1'b1;
    kick(VT[0]);
    chk(busy && !int_data_done && !dst_summary && !dst_receive, "R10 flags cleared on start",
        {31'd0, int_data_done}, 0);
    for (int c = 0; c < 2000 && !tx_valid; c++) @(negedge clk);
    held = tx_data;
    repeat (12) @(negedge clk);
    chk(tx_valid && tx_data == held, "R12 stall holds word", tx_data, held);
    chk(!mem_req && !rx_ready, "R11 single channel during stall", {31'd0, mem_req}, 0);
    bp_force = 1'b0;
    wait_idle();
    @(negedge clk);
    verify(VT[0], k0, tx0, rd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule